// File: doc/BRIEF.md
# Double-Buffered Compare Value Register

This block holds the compare value for one output-compare channel. Software writes a staging (buffer) register. The compare logic reads a separate active register. A 3-bit transfer mode selects when the staged value is copied into the active register. The copy points come from a triangular up/down counter, which supplies a strobe at its zero point and a strobe at its peak point. In some modes the copy is also gated by two event-mask down-counters: one that counts zero events and one that counts peak events.

The main counter and the mask counters are outside the block and arrive as inputs. The block decodes the mode and gates the copy. It drives the active value, a readback value, and a strobe that marks each copy.

Top module: `cmpbuf_top`

## Requirements
- R1: After reset the active value, the readback value and the transfer strobe are all 0.
- R2: With mode code 0 or code 7, buffering is off. A write sets the active value to the written data on the next clock edge. The zero and peak strobes have no effect, and the transfer strobe stays low.
- R3: With mode code 1, the staged value is copied to the active value on an edge where the zero strobe is high. The peak strobe alone does not cause a copy.
- R4: With mode code 2, the copy happens on an edge where the peak strobe is high. The zero strobe alone does not cause a copy.
- R5: With mode code 3, the copy happens on an edge where either the zero strobe or the peak strobe is high.
- R6: With mode code 4, the copy happens only on a zero strobe while the zero-event mask count is 0. A zero strobe with a nonzero zero-event mask count does not copy, and neither does any peak strobe.
- R7: With mode code 5, the copy happens only on a peak strobe while the peak-event mask count is 0. A peak strobe with a nonzero peak-event mask count does not copy, and neither does any zero strobe.
- R8: With mode code 6, the copy happens when the R6 condition or the R7 condition holds.
- R9: When a write lands in the same cycle as a qualifying event in a buffered mode (codes 1 to 6), the active value takes the previously staged value. The new data goes to the buffer only and reaches the active value at the next qualifying event.
- R10: In buffered modes the readback value is the staged value. In modes 0 and 7 it is the active value.
- R11: The transfer strobe is high for exactly the one cycle after each copy edge. In that cycle the active value equals the staged value as it was on that edge.
- R12: In buffered modes the active value does not change on an edge without a copy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for the compare value |
| wr_data | input | 16 | Data to write |
| xfer_mode | input | 3 | Transfer mode code 0..7 |
| cnt_zero | input | 1 | Counter is at its zero point this cycle |
| cnt_peak | input | 1 | Counter is at its peak point this cycle |
| zero_mask_cnt | input | 8 | Current value of the zero-event mask counter |
| peak_mask_cnt | input | 8 | Current value of the peak-event mask counter |
| active_val | output | 16 | Active compare value used by the compare logic |
| rd_data | output | 16 | Readback value |
| xfer_pulse | output | 1 | High for one cycle after each copy |

## Verification
The assertions check the following on every cycle:
- the strobe-to-value relation of the copy;
- that the active value holds between copies;
- that modes 0 and 7 never strobe and take direct writes;
- that peak strobes are ignored in mode 1;
- that masked zero events are ignored in mode 4.

Only the bench scenarios can show the following:
- the full event selection of each mode code, including the combined and masked variants;
- the same-cycle write ordering;
- the mode-dependent readback.

// File: rtl/cmpbuf_pkg.sv
package cmpbuf_pkg;

    typedef enum logic [2:0] {
        XM_DIRECT      = 3'd0,
        XM_ZERO        = 3'd1,
        XM_PEAK        = 3'd2,
        XM_EITHER      = 3'd3,
        XM_ZERO_QUAL   = 3'd4,
        XM_PEAK_QUAL   = 3'd5,
        XM_EITHER_QUAL = 3'd6,
        XM_RSVD        = 3'd7
    } xfer_mode_e;

    typedef struct packed {
        logic buffered;
        logic zero_arm;
        logic peak_arm;
        logic zero_qual;
        logic peak_qual;
    } mode_ctl_t;

endpackage

// File: rtl/cmpbuf_mode_dec.sv
module cmpbuf_mode_dec
    import cmpbuf_pkg::*;
(
    input  logic [2:0] mode_code,
    output mode_ctl_t  ctl
);
    xfer_mode_e mode;

    always_comb begin
        mode = xfer_mode_e'(mode_code);
        ctl  = '0;
        unique case (mode)
            XM_ZERO: begin
                ctl.buffered = 1'b1;
                ctl.zero_arm = 1'b1;
            end
            XM_PEAK: begin
                ctl.buffered = 1'b1;
                ctl.peak_arm = 1'b1;
            end
            XM_EITHER: begin
                ctl.buffered = 1'b1;
                ctl.zero_arm = 1'b1;
                ctl.peak_arm = 1'b1;
            end
            XM_ZERO_QUAL: begin
                ctl.buffered  = 1'b1;
                ctl.zero_arm  = 1'b1;
                ctl.zero_qual = 1'b1;
            end
            XM_PEAK_QUAL: begin
                ctl.buffered  = 1'b1;
                ctl.peak_arm  = 1'b1;
                ctl.peak_qual = 1'b1;
            end
            XM_EITHER_QUAL: begin
                ctl.buffered  = 1'b1;
                ctl.zero_arm  = 1'b1;
                ctl.peak_arm  = 1'b1;
                ctl.zero_qual = 1'b1;
                ctl.peak_qual = 1'b1;
            end
            default: ctl = '0;
        endcase
    end
endmodule

// File: rtl/cmpbuf_xfer_gate.sv
module cmpbuf_xfer_gate
    import cmpbuf_pkg::*;
#(
    parameter int MASK_W = 8
) (
    input  mode_ctl_t         ctl,
    input  logic              cnt_zero,
    input  logic              cnt_peak,
    input  logic [MASK_W-1:0] zero_mask_cnt,
    input  logic [MASK_W-1:0] peak_mask_cnt,
    output logic              xfer
);
    logic zero_mask_clear;
    logic peak_mask_clear;
    logic zero_hit;
    logic peak_hit;

    always_comb begin
        zero_mask_clear = (zero_mask_cnt == '0);
        peak_mask_clear = (peak_mask_cnt == '0);
        zero_hit = cnt_zero && ctl.zero_arm && (!ctl.zero_qual || zero_mask_clear);
        peak_hit = cnt_peak && ctl.peak_arm && (!ctl.peak_qual || peak_mask_clear);
        xfer     = ctl.buffered && (zero_hit || peak_hit);
    end
endmodule

// File: rtl/cmpbuf_store.sv
module cmpbuf_store #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              buffered,
    input  logic              xfer,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] stage_val,
    output logic [DATA_W-1:0] act_val,
    output logic              pulse
);
    typedef struct packed {
        logic [DATA_W-1:0] stage;
        logic [DATA_W-1:0] act;
        logic              pulse;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.pulse = 1'b0;
        if (wr_en) begin
            st_d.stage = wr_data;
        end
        if (!buffered) begin
            if (wr_en) begin
                st_d.act = wr_data;
            end
        end else if (xfer) begin
            st_d.act   = st_q.stage;
            st_d.pulse = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign stage_val = st_q.stage;
    assign act_val   = st_q.act;
    assign pulse     = st_q.pulse;
endmodule

// File: rtl/cmpbuf_top.sv
module cmpbuf_top
    import cmpbuf_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int MASK_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [2:0]        xfer_mode,
    input  logic              cnt_zero,
    input  logic              cnt_peak,
    input  logic [MASK_W-1:0] zero_mask_cnt,
    input  logic [MASK_W-1:0] peak_mask_cnt,
    output logic [DATA_W-1:0] active_val,
    output logic [DATA_W-1:0] rd_data,
    output logic              xfer_pulse
);
    mode_ctl_t         ctl;
    logic              xfer;
    logic [DATA_W-1:0] stage_val;

    cmpbuf_mode_dec u_dec (
        .mode_code (xfer_mode),
        .ctl       (ctl)
    );

    cmpbuf_xfer_gate #(.MASK_W(MASK_W)) u_gate (
        .ctl           (ctl),
        .cnt_zero      (cnt_zero),
        .cnt_peak      (cnt_peak),
        .zero_mask_cnt (zero_mask_cnt),
        .peak_mask_cnt (peak_mask_cnt),
        .xfer          (xfer)
    );

    cmpbuf_store #(.DATA_W(DATA_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .buffered  (ctl.buffered),
        .xfer      (xfer),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .stage_val (stage_val),
        .act_val   (active_val),
        .pulse     (xfer_pulse)
    );

    assign rd_data = ctl.buffered ? stage_val : active_val;
endmodule

// File: rtl/cmpbuf_checker.sv
module cmpbuf_checker #(
    parameter int DATA_W = 16,
    parameter int MASK_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [DATA_W-1:0] wr_data,
    input logic [2:0]        xfer_mode,
    input logic              cnt_zero,
    input logic [MASK_W-1:0] zero_mask_cnt,
    input logic [DATA_W-1:0] active_val,
    input logic [DATA_W-1:0] stage_val,
    input logic              xfer_pulse
);
    logic direct_mode;
    assign direct_mode = (xfer_mode == 3'd0) || (xfer_mode == 3'd7);

    // R11: the strobe marks a copy of the previously staged value
    a_r11_pulse_copies: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_pulse |-> active_val == $past(stage_val));

    // R12: a buffered mode with no copy holds the active value
    a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!direct_mode) && !xfer_pulse) |-> $stable(active_val));

    // R2: direct modes never strobe
    a_r2_no_pulse_direct: assert property (@(posedge clk) disable iff (!rst_n)
        $past(direct_mode) |-> !xfer_pulse);

    // R2: direct write lands in the active value
    a_r2_direct_write: assert property (@(posedge clk) disable iff (!rst_n)
        $past(direct_mode && wr_en) |-> active_val == $past(wr_data));

    // R3: mode 1 copies only on zero events
    a_r3_zero_only: assert property (@(posedge clk) disable iff (!rst_n)
        $past(xfer_mode == 3'd1 && !cnt_zero) |-> !xfer_pulse);

    // R6: mode 4 ignores zero events with a nonzero mask count
    a_r6_masked_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $past(xfer_mode == 3'd4 && zero_mask_cnt != '0) |-> !xfer_pulse);
endmodule

bind cmpbuf_top cmpbuf_checker #(.DATA_W(DATA_W), .MASK_W(MASK_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_en         (wr_en),
    .wr_data       (wr_data),
    .xfer_mode     (xfer_mode),
    .cnt_zero      (cnt_zero),
    .zero_mask_cnt (zero_mask_cnt),
    .active_val    (active_val),
    .stage_val     (stage_val),
    .xfer_pulse    (xfer_pulse)
);

// File: tb/cmpbuf_top_test.sv
`timescale 1ns/1ps
module cmpbuf_top_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic [2:0]  xfer_mode = '0;
    logic        cnt_zero = 1'b0;
    logic        cnt_peak = 1'b0;
    logic [7:0]  zero_mask_cnt = '0;
    logic [7:0]  peak_mask_cnt = '0;
    logic [15:0] active_val;
    logic [15:0] rd_data;
    logic        xfer_pulse;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    cmpbuf_top uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .xfer_mode(xfer_mode), .cnt_zero(cnt_zero), .cnt_peak(cnt_peak),
        .zero_mask_cnt(zero_mask_cnt), .peak_mask_cnt(peak_mask_cnt),
        .active_val(active_val), .rd_data(rd_data), .xfer_pulse(xfer_pulse)
    );

    task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // one clock edge with the given stimulus, then back to idle
    task automatic step(bit we, logic [15:0] d, bit z, bit p,
                        logic [7:0] zm, logic [7:0] pm);
        @(negedge clk);
        wr_en = we; wr_data = d; cnt_zero = z; cnt_peak = p;
        zero_mask_cnt = zm; peak_mask_cnt = pm;
        @(negedge clk);
        wr_en = 1'b0; cnt_zero = 1'b0; cnt_peak = 1'b0;
        zero_mask_cnt = 8'd0; peak_mask_cnt = 8'd0;
    endtask

    task automatic t_reset();
        chk("R1 active", active_val, 16'h0);
        chk("R1 rd", rd_data, 16'h0);
        chk("R1 pulse", {15'd0, xfer_pulse}, 16'd0);
    endtask

    task automatic t_direct();
        xfer_mode = 3'd0;
        step(1, 16'h1234, 0, 0, 0, 0);
        chk("R2 mode0 write", active_val, 16'h1234);
        chk("R2 mode0 no pulse", {15'd0, xfer_pulse}, 16'd0);
        chk("R10 mode0 rd", rd_data, 16'h1234);
        step(0, 0, 1, 1, 0, 0);
        chk("R2 mode0 events ignored", {15'd0, xfer_pulse}, 16'd0);
        chk("R2 mode0 value kept", active_val, 16'h1234);
        xfer_mode = 3'd7;
        step(1, 16'hBEEF, 1, 0, 0, 0);
        chk("R2 mode7 write", active_val, 16'hBEEF);
        chk("R2 mode7 no pulse", {15'd0, xfer_pulse}, 16'd0);
    endtask

    task automatic t_zero();
        xfer_mode = 3'd1;
        step(1, 16'hA1A1, 0, 0, 0, 0);
        chk("R12 mode1 staged only", active_val, 16'hBEEF);
        chk("R10 mode1 rd stage", rd_data, 16'hA1A1);
        step(0, 0, 0, 1, 0, 0);
        chk("R3 peak ignored", active_val, 16'hBEEF);
        step(0, 0, 1, 0, 0, 0);
        chk("R3 zero copies", active_val, 16'hA1A1);
        chk("R11 pulse", {15'd0, xfer_pulse}, 16'd1);
        @(negedge clk);
        chk("R11 pulse one cycle", {15'd0, xfer_pulse}, 16'd0);
    endtask

    task automatic t_peak();
        xfer_mode = 3'd2;
        step(1, 16'h2222, 0, 0, 0, 0);
        step(0, 0, 1, 0, 0, 0);
        chk("R4 zero ignored", active_val, 16'hA1A1);
        step(0, 0, 0, 1, 0, 0);
        chk("R4 peak copies", active_val, 16'h2222);
    endtask

    task automatic t_either();
        xfer_mode = 3'd3;
        step(1, 16'h3333, 0, 0, 0, 0);
        step(0, 0, 1, 0, 0, 0);
        chk("R5 zero copies", active_val, 16'h3333);
        step(1, 16'h3334, 0, 0, 0, 0);
        step(0, 0, 0, 1, 0, 0);
        chk("R5 peak copies", active_val, 16'h3334);
    endtask

    task automatic t_zero_qual();
        xfer_mode = 3'd4;
        step(1, 16'h4444, 0, 0, 0, 0);
        step(0, 0, 1, 0, 8'd2, 0);
        chk("R6 masked zero ignored", active_val, 16'h3334);
        step(0, 0, 0, 1, 0, 0);
        chk("R6 peak ignored", active_val, 16'h3334);
        step(0, 0, 1, 0, 0, 0);
        chk("R6 clear zero copies", active_val, 16'h4444);
    endtask

    task automatic t_peak_qual();
        xfer_mode = 3'd5;
        step(1, 16'h5555, 0, 0, 0, 0);
        step(0, 0, 0, 1, 0, 8'd1);
        chk("R7 masked peak ignored", active_val, 16'h4444);
        step(0, 0, 1, 0, 0, 0);
        chk("R7 zero ignored", active_val, 16'h4444);
        step(0, 0, 0, 1, 0, 0);
        chk("R7 clear peak copies", active_val, 16'h5555);
    endtask

    task automatic t_either_qual();
        xfer_mode = 3'd6;
        step(1, 16'h6666, 0, 0, 0, 0);
        step(0, 0, 1, 0, 8'd1, 0);
        chk("R8 masked zero ignored", active_val, 16'h5555);
        step(0, 0, 0, 1, 0, 8'd3);
        chk("R8 masked peak ignored", active_val, 16'h5555);
        step(0, 0, 1, 0, 0, 0);
        chk("R8 clear zero copies", active_val, 16'h6666);
        step(1, 16'h6667, 0, 0, 0, 0);
        step(0, 0, 0, 1, 0, 0);
        chk("R8 clear peak copies", active_val, 16'h6667);
    endtask

    task automatic t_same_cycle();
        xfer_mode = 3'd1;
        step(1, 16'h7777, 0, 0, 0, 0);
        step(1, 16'h8888, 1, 0, 0, 0);
        chk("R9 old stage copied", active_val, 16'h7777);
        chk("R9 new data staged", rd_data, 16'h8888);
        step(0, 0, 1, 0, 0, 0);
        chk("R9 new data at next event", active_val, 16'h8888);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_direct();
        t_zero();
        t_peak();
        t_either();
        t_zero_qual();
        t_peak_qual();
        t_either_qual();
        t_same_cycle();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule